// File: doc/BRIEF.md
# Dual-Bus Boundary Register with Signature, Pattern and Count Modes

This block is the boundary register that sits around a two-bus transceiver with `W` pins on each side. Every pin has two cells, one on the A side and one on the B side, so a test can observe or force A and B on their own. Two more cells hold the output enables of the two buses. The block is clocked by the test clock. Instead of a full test-access state machine it takes a mode code and four strobes: capture, shift, update and run. Each strobe acts on the rising test-clock edge in which it is high.

In sample mode the pins follow the transceiver core, whatever the strobes do. The cells only take snapshots and move them out serially. In the test modes the core is cut off and the update latches drive the pins. Three of these modes let the latches work on their own under the run strobe:
- a multiple-input signature register folds the A-bus inputs into the A latches;
- a pseudo-random generator steps the B latches;
- a combined mode compresses the A inputs while the B latches count up in binary, which suits stepping through memory addresses.

Pins are modelled as separate input data, output data and output enable. Mode codes: 0 sample, 1 external test, 2 signature, 3 pattern, 4 signature plus count. Codes 5 to 7 behave as sample.

Top module: `dual_bus_boundary_reg`

## Requirements
- R1: The chain holds N = 2W+2 cells. Bits W-1..0 are the A cells (bit i is pin i), bits 2W-1..W are the B cells, bit 2W is the A enable cell and bit 2W+1 is the B enable cell. Each shift edge moves `tdi` into bit 0 and every bit k into bit k+1. `tdo` always shows bit N-1.
- R2: In modes 0 and 1, a capture edge loads `a_pad_in`, `b_pad_in`, the current `a_pad_oe` and the current `b_pad_oe` into their cells.
- R3: In sample mode, `a_pad_out`, `a_pad_oe`, `b_pad_out` and `b_pad_oe` equal the core's outputs and enables at all times, during capture, shift and update as well.
- R4: The update latches load the whole chain only on an update edge. Shifting leaves the latches and the driven pins unchanged.
- R5: In modes 1 to 4 the pins are driven from the latches: the A latches and the A enable latch drive the A side, and the B latches and the B enable latch drive the B side. The core outputs are ignored.
- R6: In mode 2, each run edge replaces the A latches with ({s[W-2:0],0}) XOR (s[W-1] ? POLY : 0) XOR `a_pad_in`, where s is the old A latch value. The B latches hold.
- R7: In mode 3, each run edge replaces the B latches with ({s[W-2:0],0}) XOR (s[W-1] ? POLY : 0). An all-zero seed stays zero.
- R8: In mode 4, each run edge steps the A latches as in R6 and adds one to the B latches, which wrap from all ones to zero.
- R9: In modes 2 to 4, a capture edge loads the A cells from the A latches and the B cells from the B latches, so the result can be read out. The enable cells capture the pin enables.
- R10: Reset (`trst_n` low) clears all cells and latches. `tdo` then reads 0, and in the test modes both buses are tri-stated.
- R11: Capture wins over shift in the same edge. Update wins over run in the same edge. Run has no effect in modes 0 and 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 3 | Mode code (see above) |
| capture_en | input | 1 | Capture strobe |
| shift_en | input | 1 | Shift strobe |
| update_en | input | 1 | Update strobe |
| run_en | input | 1 | Run strobe for the signature, pattern and count modes |
| tdi | input | 1 | Serial data into the chain |
| tdo | output | 1 | Serial data out of the chain |
| core_a_out | input | W | Core data toward bus A |
| core_a_oe | input | 1 | Core enable for bus A |
| core_b_out | input | W | Core data toward bus B |
| core_b_oe | input | 1 | Core enable for bus B |
| a_pad_in | input | W | Levels seen on the A pins |
| b_pad_in | input | W | Levels seen on the B pins |
| a_pad_out | output | W | Data driven onto the A pins |
| a_pad_oe | output | 1 | Enable for the A pins |
| b_pad_out | output | W | Data driven onto the B pins |
| b_pad_oe | output | 1 | Enable for the B pins |

## Verification
On every cycle the assertions check four things: the pins stay transparent in sample mode, the driven pins hold steady between updates in external test, the B side holds during signature compression, and the count and pattern steps stay correct from one edge to the next. Only the bench scenarios can show the serial order of the chain, what each mode captures, the signature values after several input words, the counter wrap, and the strobe priorities. Each of these needs a full shift-out, or an expected value built up over many edges.

// File: rtl/bsr_pkg.sv
package bsr_pkg;
  typedef enum logic [2:0] {
    MODE_SAMPLE = 3'd0,
    MODE_EXTEST = 3'd1,
    MODE_SIG    = 3'd2,
    MODE_PRPG   = 3'd3,
    MODE_SIGCNT = 3'd4
  } bsr_mode_e;

  // Pins are driven from the latches in every defined non-sample mode
  function automatic logic mode_is_test(input logic [2:0] m);
    return (m >= 3'd1) && (m <= 3'd4);
  endfunction

  // Modes whose latches evolve on the run strobe
  function automatic logic mode_is_run(input logic [2:0] m);
    return (m >= 3'd2) && (m <= 3'd4);
  endfunction
endpackage

// File: rtl/bsr_shift_chain.sv
module bsr_shift_chain #(
  parameter int W = 9,
  localparam int N = 2 * W + 2
) (
  input  logic         tck,
  input  logic         trst_n,
  input  logic         capture_en,
  input  logic         shift_en,
  input  logic         tdi,
  input  logic [N-1:0] cap_vec,
  output logic [N-1:0] cells,
  output logic         tdo
);
  // Capture has priority over shift (R11)
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)         cells <= '0;
    else if (capture_en) cells <= cap_vec;
    else if (shift_en)   cells <= {cells[N-2:0], tdi};
  end

  assign tdo = cells[N-1];
endmodule

// File: rtl/bsr_update_bank.sv
module bsr_update_bank
  import bsr_pkg::*;
#(
  parameter int         W    = 9,
  parameter logic [W-1:0] POLY = 9'h011,
  localparam int        N    = 2 * W + 2
) (
  input  logic         tck,
  input  logic         trst_n,
  input  logic         update_en,
  input  logic         run_en,
  input  logic [2:0]   mode,
  input  logic [N-1:0] cells,
  input  logic [W-1:0] a_sense,
  output logic [N-1:0] lat
);
  logic [W-1:0] lat_a, lat_b;
  logic [W-1:0] misr_next, lfsr_next, cnt_next;
  logic [W-1:0] fb_a, fb_b;

  assign lat_a = lat[W-1:0];
  assign lat_b = lat[2*W-1:W];

  // Per-bit feedback taps, one XOR column per pin
  for (genvar i = 0; i < W; i++) begin : g_tap
    assign fb_a[i] = POLY[i] & lat_a[W-1];
    assign fb_b[i] = POLY[i] & lat_b[W-1];
  end

  always_comb begin
    misr_next = {lat_a[W-2:0], 1'b0} ^ fb_a ^ a_sense;
    lfsr_next = {lat_b[W-2:0], 1'b0} ^ fb_b;
    cnt_next  = lat_b + W'(1);
  end

  // Update has priority over run (R11); run is inert outside run modes
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      lat <= '0;
    end else if (update_en) begin
      lat <= cells;
    end else if (run_en && mode_is_run(mode)) begin
      unique case (bsr_mode_e'(mode))
        MODE_SIG:    lat[W-1:0] <= misr_next;
        MODE_PRPG:   lat[2*W-1:W] <= lfsr_next;
        MODE_SIGCNT: begin
          lat[W-1:0]   <= misr_next;
          lat[2*W-1:W] <= cnt_next;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/bsr_pad_mux.sv
module bsr_pad_mux
  import bsr_pkg::*;
#(
  parameter int W = 9,
  localparam int N = 2 * W + 2
) (
  input  logic [2:0]   mode,
  input  logic [N-1:0] lat,
  input  logic [W-1:0] core_a_out,
  input  logic         core_a_oe,
  input  logic [W-1:0] core_b_out,
  input  logic         core_b_oe,
  output logic [W-1:0] a_pad_out,
  output logic         a_pad_oe,
  output logic [W-1:0] b_pad_out,
  output logic         b_pad_oe
);
  logic test;
  assign test = mode_is_test(mode);

  for (genvar i = 0; i < W; i++) begin : g_pin
    assign a_pad_out[i] = test ? lat[i]     : core_a_out[i];
    assign b_pad_out[i] = test ? lat[W + i] : core_b_out[i];
  end

  assign a_pad_oe = test ? lat[2*W]     : core_a_oe;
  assign b_pad_oe = test ? lat[2*W + 1] : core_b_oe;
endmodule

// File: rtl/dual_bus_boundary_reg.sv
module dual_bus_boundary_reg
  import bsr_pkg::*;
#(
  parameter int         W    = 9,
  parameter logic [W-1:0] POLY = 9'h011
) (
  input  logic         tck,
  input  logic         trst_n,
  input  logic [2:0]   mode,
  input  logic         capture_en,
  input  logic         shift_en,
  input  logic         update_en,
  input  logic         run_en,
  input  logic         tdi,
  output logic         tdo,
  input  logic [W-1:0] core_a_out,
  input  logic         core_a_oe,
  input  logic [W-1:0] core_b_out,
  input  logic         core_b_oe,
  input  logic [W-1:0] a_pad_in,
  input  logic [W-1:0] b_pad_in,
  output logic [W-1:0] a_pad_out,
  output logic         a_pad_oe,
  output logic [W-1:0] b_pad_out,
  output logic         b_pad_oe
);
  localparam int N = 2 * W + 2;

  logic [N-1:0] cells, lat, cap_vec;
  logic         readback;

  // Run modes capture the latch contents so signatures can be read out
  assign readback = mode_is_run(mode);
  assign cap_vec  = {b_pad_oe, a_pad_oe,
                     readback ? lat[2*W-1:W] : b_pad_in,
                     readback ? lat[W-1:0]   : a_pad_in};

  bsr_shift_chain #(.W(W)) u_chain (
    .tck(tck), .trst_n(trst_n), .capture_en(capture_en), .shift_en(shift_en),
    .tdi(tdi), .cap_vec(cap_vec), .cells(cells), .tdo(tdo)
  );

  bsr_update_bank #(.W(W), .POLY(POLY)) u_bank (
    .tck(tck), .trst_n(trst_n), .update_en(update_en), .run_en(run_en),
    .mode(mode), .cells(cells), .a_sense(a_pad_in), .lat(lat)
  );

  bsr_pad_mux #(.W(W)) u_mux (
    .mode(mode), .lat(lat),
    .core_a_out(core_a_out), .core_a_oe(core_a_oe),
    .core_b_out(core_b_out), .core_b_oe(core_b_oe),
    .a_pad_out(a_pad_out), .a_pad_oe(a_pad_oe),
    .b_pad_out(b_pad_out), .b_pad_oe(b_pad_oe)
  );
endmodule

// File: rtl/bsr_checker.sv
module bsr_checker #(
  parameter int W = 9
) (
  input logic         tck,
  input logic         trst_n,
  input logic [2:0]   mode,
  input logic         update_en,
  input logic         run_en,
  input logic [W-1:0] core_a_out,
  input logic         core_a_oe,
  input logic [W-1:0] core_b_out,
  input logic         core_b_oe,
  input logic [W-1:0] a_pad_out,
  input logic         a_pad_oe,
  input logic [W-1:0] b_pad_out,
  input logic         b_pad_oe
);
  assert_sample_transparent_R3: assert property (@(posedge tck) disable iff (!trst_n)
    (mode == 3'd0) |-> (a_pad_out == core_a_out && a_pad_oe == core_a_oe &&
                        b_pad_out == core_b_out && b_pad_oe == core_b_oe));

  assert_latch_hold_R4: assert property (@(posedge tck) disable iff (!trst_n)
    (mode == 3'd1 && !update_en) |=>
      (mode != 3'd1 || ($stable(a_pad_out) && $stable(b_pad_out) &&
                        $stable(a_pad_oe) && $stable(b_pad_oe))));

  assert_sig_b_hold_R6: assert property (@(posedge tck) disable iff (!trst_n)
    (mode == 3'd2 && !update_en) |=> (mode != 3'd2 || $stable(b_pad_out)));

  assert_prpg_nonzero_R7: assert property (@(posedge tck) disable iff (!trst_n)
    (mode == 3'd3 && run_en && !update_en && b_pad_out != '0) |=>
      (mode != 3'd3 || b_pad_out != '0));

  assert_count_step_R8: assert property (@(posedge tck) disable iff (!trst_n)
    (mode == 3'd4 && run_en && !update_en) |=>
      (mode != 3'd4 || b_pad_out == W'($past(b_pad_out) + W'(1))));
endmodule

bind dual_bus_boundary_reg bsr_checker #(.W(W)) u_bsr_checker (
  .tck(tck), .trst_n(trst_n), .mode(mode), .update_en(update_en), .run_en(run_en),
  .core_a_out(core_a_out), .core_a_oe(core_a_oe),
  .core_b_out(core_b_out), .core_b_oe(core_b_oe),
  .a_pad_out(a_pad_out), .a_pad_oe(a_pad_oe),
  .b_pad_out(b_pad_out), .b_pad_oe(b_pad_oe)
);

// File: tb/tb_dual_bus_boundary_reg.sv
module tb_dual_bus_boundary_reg;
  localparam int W = 9;
  localparam int N = 2 * W + 2;
  localparam logic [W-1:0] POLY = 9'h011;

  logic tck = 1'b0, trst_n = 1'b0;
  logic [2:0] mode = 3'd0;
  logic capture_en = 0, shift_en = 0, update_en = 0, run_en = 0, tdi = 0;
  logic tdo;
  logic [W-1:0] core_a_out = '0, core_b_out = '0, a_pad_in = '0, b_pad_in = '0;
  logic core_a_oe = 0, core_b_oe = 0;
  logic [W-1:0] a_pad_out, b_pad_out;
  logic a_pad_oe, b_pad_oe;

  int n_chk = 0, n_fail = 0;

  always #2 tck = ~tck;

  dual_bus_boundary_reg #(.W(W), .POLY(POLY)) dut (.*);

  // Table: {shift vector, expected A out, expected B out, expected A oe, expected B oe}
  localparam int NV = 4;
  localparam logic [N+2*W+1:0] TAB [NV] = '{
    {{1'b0, 1'b1, 9'h0AA, 9'h155}, 9'h155, 9'h0AA, 1'b1, 1'b0},
    {{1'b1, 1'b0, 9'h000, 9'h1FF}, 9'h1FF, 9'h000, 1'b0, 1'b1},
    {{1'b1, 1'b1, 9'h1FF, 9'h000}, 9'h000, 9'h1FF, 1'b1, 1'b1},
    {{1'b0, 1'b0, 9'h0F0, 9'h123}, 9'h123, 9'h0F0, 1'b0, 1'b0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] misr(input logic [W-1:0] s, input logic [W-1:0] d);
    return {s[W-2:0], 1'b0} ^ (s[W-1] ? POLY : '0) ^ d;
  endfunction

  function automatic logic [N-1:0] mk(input logic eb, input logic ea,
                                      input logic [W-1:0] b, input logic [W-1:0] a);
    return {eb, ea, b, a};
  endfunction

  task automatic shift_vec(input logic [N-1:0] v, output logic [N-1:0] o);
    for (int i = N - 1; i >= 0; i--) begin
      @(negedge tck);
      tdi = v[i];
      shift_en = 1'b1;
      o[i] = tdo;
    end
    @(negedge tck);
    shift_en = 1'b0;
  endtask

  task automatic strobe_update();
    @(negedge tck); update_en = 1'b1;
    @(negedge tck); update_en = 1'b0;
  endtask

  task automatic strobe_capture();
    @(negedge tck); capture_en = 1'b1;
    @(negedge tck); capture_en = 1'b0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge tck);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    logic [N-1:0] o, prev, v;
    logic [W-1:0] s, exp_b;
    logic [W-1:0] dat [5];
    dat = '{9'h1A3, 9'h04F, 9'h100, 9'h0FF, 9'h0C1};

    // R10: reset state
    repeat (3) @(negedge tck);
    chk("R10 tdo in reset", tdo, 0);
    mode = 3'd1; #1;
    chk("R10 a oe in reset", a_pad_oe, 0);
    chk("R10 b oe in reset", b_pad_oe, 0);
    chk("R10 a out in reset", a_pad_out, 0);
    @(negedge tck); trst_n = 1'b1;

    // R5 / R1: table walk in external test mode
    prev = '0;
    for (int k = 0; k < NV; k++) begin
      v = TAB[k][N+2*W+1:2*W+2];
      shift_vec(v, o);
      chk("R1 shifted-out previous contents", o, prev);
      strobe_update();
      chk("R5 a_pad_out", a_pad_out, TAB[k][2*W+1:W+2]);
      chk("R5 b_pad_out", b_pad_out, TAB[k][W+1:2]);
      chk("R5 a_pad_oe", a_pad_oe, TAB[k][1]);
      chk("R5 b_pad_oe", b_pad_oe, TAB[k][0]);
      prev = v;
    end
    core_a_out = 9'h0F3; core_b_out = 9'h1C4; core_a_oe = 1; core_b_oe = 1; #1;
    chk("R5 core ignored in test mode", a_pad_out, 9'h123);

    // R3 / R2: sample mode transparency and capture
    @(negedge tck);
    mode = 3'd0; core_b_oe = 0; a_pad_in = 9'h03C; b_pad_in = 9'h155; #1;
    chk("R3 a_pad_out follows core", a_pad_out, 9'h0F3);
    chk("R3 b_pad_oe follows core", b_pad_oe, 0);
    strobe_capture();
    shift_vec(mk(1, 1, 9'h1FF, 9'h1FF), o);
    chk("R2 sample capture", o, mk(0, 1, 9'h155, 9'h03C));
    strobe_update();
    chk("R3 a_pad_out after update", a_pad_out, 9'h0F3);
    chk("R3 b_pad_out after update", b_pad_out, 9'h1C4);
    chk("R3 a_pad_oe after update", a_pad_oe, 1);

    // R4: shifting leaves latches alone
    @(negedge tck); mode = 3'd1;
    shift_vec(mk(1, 0, 9'h0AA, 9'h055), o);
    strobe_update();
    shift_vec(mk(0, 1, 9'h111, 9'h1EE), o);
    chk("R4 a held during shift", a_pad_out, 9'h055);
    chk("R4 b oe held during shift", b_pad_oe, 1);
    strobe_update();
    chk("R4 a after update", a_pad_out, 9'h1EE);

    // R11: run ignored in external test
    for (int k = 0; k < 3; k++) begin
      @(negedge tck); run_en = 1'b1;
    end
    @(negedge tck); run_en = 1'b0;
    chk("R11 run ignored a", a_pad_out, 9'h1EE);
    chk("R11 run ignored b", b_pad_out, 9'h111);

    // R11: capture beats shift
    a_pad_in = 9'h0C3; b_pad_in = 9'h13C;
    @(negedge tck); capture_en = 1'b1; shift_en = 1'b1; tdi = 1'b1;
    @(negedge tck); capture_en = 1'b0; shift_en = 1'b0;
    shift_vec('0, o);
    chk("R11 capture over shift", o, mk(0, 1, 9'h13C, 9'h0C3));

    // R6 / R9: signature compression
    @(negedge tck); mode = 3'd2;
    shift_vec(mk(1, 0, 9'h033, 9'h0A5), o);
    strobe_update();
    s = 9'h0A5;
    for (int k = 0; k < 5; k++) begin
      @(negedge tck); a_pad_in = dat[k]; run_en = 1'b1;
      s = misr(s, dat[k]);
    end
    @(negedge tck); run_en = 1'b0;
    chk("R6 signature on pins", a_pad_out, s);
    chk("R6 b held", b_pad_out, 9'h033);
    strobe_capture();
    shift_vec('0, o);
    chk("R9 signature readout", o, mk(1, 0, 9'h033, s));

    // R7: pseudo-random pattern
    @(negedge tck); mode = 3'd3;
    shift_vec(mk(1, 0, 9'h001, 9'h000), o);
    strobe_update();
    exp_b = 9'h001;
    for (int k = 0; k < 12; k++) begin
      @(negedge tck); run_en = 1'b1;
      exp_b = {exp_b[W-2:0], 1'b0} ^ (exp_b[W-1] ? POLY : '0);
    end
    @(negedge tck); run_en = 1'b0;
    chk("R7 pattern after 12 steps", b_pad_out, exp_b);
    shift_vec(mk(1, 0, 9'h000, 9'h000), o);
    strobe_update();
    for (int k = 0; k < 4; k++) begin
      @(negedge tck); run_en = 1'b1;
    end
    @(negedge tck); run_en = 1'b0;
    chk("R7 zero seed stays zero", b_pad_out, 0);

    // R8: signature plus count with wrap
    @(negedge tck); mode = 3'd4;
    shift_vec(mk(1, 0, 9'h1FE, 9'h000), o);
    strobe_update();
    s = '0; exp_b = 9'h1FE;
    for (int k = 0; k < 3; k++) begin
      @(negedge tck); a_pad_in = dat[k]; run_en = 1'b1;
      @(negedge tck); run_en = 1'b0;
      s = misr(s, dat[k]);
      exp_b = exp_b + 9'd1;
      chk("R8 count step", b_pad_out, exp_b);
      chk("R8 signature step", a_pad_out, s);
    end

    // R11: update beats run
    shift_vec(mk(1, 0, 9'h050, 9'h007), o);
    @(negedge tck); update_en = 1'b1; run_en = 1'b1;
    @(negedge tck); update_en = 1'b0; run_en = 1'b0;
    chk("R11 update over run b", b_pad_out, 9'h050);
    chk("R11 update over run a", a_pad_out, 9'h007);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule